// File: doc/BRIEF.md
# Parallel Port and Interrupt Flag Register Unit

This unit is a byte-wide register file on a simple write-strobe bus. It holds two 8-bit parallel ports, each paired with a direction register, plus a small interrupt controller made of a seven-bit flag register and a seven-bit enable register. The interrupt controller drives one active-high request line. Two more control bytes are also held here. One is an auxiliary control byte that is stored and read back. The other is a peripheral control byte whose bit 1 drives the CA2 output line.

Ports are indexed so that port B sits at offset 0 and port A at offset 1. Their direction registers sit two offsets higher. Port A can also be written at offset 15. That alias updates the port without acknowledging its handshake flags.

External pin logic can overwrite individual port bits through per-bit update strobes. Neighbouring timer, shift and handshake units raise or drop their flag bits through set and clear strobe vectors. This unit does no edge detection, counting or shifting of its own.

Reads are combinational from the address. They have no side effects.

Top module: `port_irq_regs`

## Requirements
- R1: Only address bits 3..0 are decoded, so an address and the same address with different upper bits reach the same register. Offsets 4 to 10 read as 0x00, and writes to them change nothing.
- R2: A port write (port B at offset 0, port A at offset 1 or 15) stores the write data ANDed with that port's direction register. The port's output pins show the stored value ANDed with the direction register.
- R3: A port read returns the stored bits where the direction bit is 1, and returns 1 where the direction bit is 0. Direction registers at offsets 2 (B) and 3 (A) read back as written.
- R4: For each port, a bit whose pin-update strobe is high takes the pin value on that clock. In the same cycle this update overrides a bus write to that port.
- R5: The flag bit positions are: 0 = CA2, 1 = CA1, 2 = shift, 3 = CB2, 4 = CB1, 5 = timer 2, 6 = timer 1. A write to offset 0 clears flags 4 and 3. A write to offset 1 clears flags 1 and 0.
- R6: A write to offset 15 updates port A exactly as offset 1 does, but clears no flag.
- R7: An enable-register write (offset 14) with data bit 7 set sets every enable bit that is 1 in data bits 6..0. With bit 7 clear, it clears those bits instead. A read of offset 14 returns bit 7 as 1 and bits 6..0 as the enables.
- R8: A high flag-set strobe sets its flag bit on the next clock, and a flag-clear strobe clears it. When both strobes are high for the same bit in the same cycle, the bit is set.
- R9: Writing the flag register (offset 13) clears each flag whose data bit is 1. Bits written as 0 are left unchanged.
- R10: A read of offset 13 returns the flags in bits 6..0. Bit 7 reads as 1 exactly when some flag and its enable are both 1, and the irq output equals that bit.
- R11: Offsets 11 and 12 store and read back a full byte. The CA2 output equals bit 1 of the byte stored at offset 12.
- R12: After reset, all stored registers are zero. Ports therefore read 0xFF, the enable register reads 0x80, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | AW | Register address; bits 3..0 decoded |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| pa_pin_we | input | 8 | Per-bit update strobes for port A |
| pa_pin_val | input | 8 | Pin values for port A bits |
| pb_pin_we | input | 8 | Per-bit update strobes for port B |
| pb_pin_val | input | 8 | Pin values for port B bits |
| flag_set | input | 7 | Flag set strobes from neighbouring units |
| flag_clr | input | 7 | Flag clear strobes from neighbouring units |
| pa_out | output | 8 | Port A output pin values |
| pa_dir | output | 8 | Port A direction (1 = output) |
| pb_out | output | 8 | Port B output pin values |
| pb_dir | output | 8 | Port B direction (1 = output) |
| ca2_out | output | 1 | CA2 control line |
| irq | output | 1 | Interrupt request, active high |

## Verification
Read data is combinational, so it is due in the same cycle that the address is presented. Every stored effect appears on the first rising edge after the stimulus is held. This covers writes, pin updates and flag strobes. The request line follows the flag and enable registers with no further delay, so it is due on that same edge. The bench changes inputs on the falling edge and compares every output with its model 1 ns later. At that point the model has already applied the previous rising edge. No result is therefore sampled at the edge that produces it.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int DW = 8;
  localparam int NF = DW - 1;

  localparam logic [3:0] OFS_PB    = 4'h0;
  localparam logic [3:0] OFS_PA    = 4'h1;
  localparam logic [3:0] OFS_AUX   = 4'hB;
  localparam logic [3:0] OFS_PCR   = 4'hC;
  localparam logic [3:0] OFS_FLAG  = 4'hD;
  localparam logic [3:0] OFS_EN    = 4'hE;
  localparam logic [3:0] OFS_PA_NQ = 4'hF;

  localparam int FLG_CA2 = 0;
  localparam int FLG_CA1 = 1;
  localparam int FLG_CB2 = 3;
  localparam int FLG_CB1 = 4;

  localparam logic [NF-1:0] HS_MASK_A = NF'((1 << FLG_CA1) | (1 << FLG_CA2));
  localparam logic [NF-1:0] HS_MASK_B = NF'((1 << FLG_CB1) | (1 << FLG_CB2));

  localparam int CA2_BIT = 1;

  // Value seen on a port read: input positions float high.
  function automatic logic [DW-1:0] port_view(logic [DW-1:0] data, logic [DW-1:0] dir);
    return (data & dir) | ~dir;
  endfunction

  // Per-bit override of a port value by pin strobes.
  function automatic logic [DW-1:0] pin_merge(logic [DW-1:0] cur, logic [DW-1:0] we,
                                              logic [DW-1:0] val);
    return (cur & ~we) | (val & we);
  endfunction

  // Enable update: top bit selects set or clear of the marked bits.
  function automatic logic [NF-1:0] en_next(logic [NF-1:0] cur, logic [DW-1:0] wd);
    return wd[DW-1] ? (cur | wd[NF-1:0]) : (cur & ~wd[NF-1:0]);
  endfunction

  // Flag update: set requests dominate clear requests.
  function automatic logic [NF-1:0] flag_next(logic [NF-1:0] cur, logic [NF-1:0] set,
                                              logic [NF-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [DW-1:0] status_byte(logic [NF-1:0] flags, logic [NF-1:0] en);
    return {|(flags & en), flags};
  endfunction
endpackage

// File: rtl/pir_port.sv
module pir_port
  import pir_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we,
  input  logic          dir_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_we,
  input  logic [DW-1:0] pin_val,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] dir_q
);
  logic [DW-1:0] bus_value;

  assign bus_value = data_we ? (wdata & dir_q) : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= pin_merge(bus_value, pin_we, pin_val);
      if (dir_we) dir_q <= wdata;
    end
  end
endmodule

// File: rtl/pir_irq.sv
module pir_irq
  import pir_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_req,
  input  logic [NF-1:0] clr_req,
  input  logic [NF-1:0] hs_clr,
  input  logic          flag_we,
  input  logic          en_we,
  input  logic [DW-1:0] wdata,
  output logic [NF-1:0] flag_q,
  output logic [NF-1:0] en_q,
  output logic          irq
);
  logic [NF-1:0] clr_all;
  logic [NF-1:0] bus_clr;

  assign bus_clr = flag_we ? wdata[NF-1:0] : '0;
  assign clr_all = clr_req | hs_clr | bus_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_next(flag_q, set_req, clr_all);
      if (en_we) en_q <= en_next(en_q, wdata);
    end
  end

  assign irq = |(flag_q & en_q);
endmodule

// File: rtl/port_irq_regs.sv
module port_irq_regs
  import pir_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pa_pin_we,
  input  logic [DW-1:0] pa_pin_val,
  input  logic [DW-1:0] pb_pin_we,
  input  logic [DW-1:0] pb_pin_val,
  input  logic [NF-1:0] flag_set,
  input  logic [NF-1:0] flag_clr,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_dir,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_dir,
  output logic          ca2_out,
  output logic          irq
);
  localparam int NPORT = 2;  // index 0 = port B, 1 = port A

  logic [3:0]    ofs;
  logic [DW-1:0] port_q   [NPORT];
  logic [DW-1:0] dir_q    [NPORT];
  logic [DW-1:0] pin_we_v [NPORT];
  logic [DW-1:0] pin_val_v[NPORT];
  logic [NPORT-1:0] port_wr;
  logic [NPORT-1:0] dir_wr;
  logic [NF-1:0] flag_q;
  logic [NF-1:0] ier_q;
  logic [NF-1:0] hs_clr;
  logic [DW-1:0] aux_q;
  logic [DW-1:0] pcr_q;
  logic          wr_flag;
  logic          wr_en;

  assign ofs = bus_addr[3:0];

  if (AW > 4) begin : g_addr_hi
    logic unused_addr_hi;
    assign unused_addr_hi = ^bus_addr[AW-1:4];
  end

  assign pin_we_v[0]  = pb_pin_we;
  assign pin_val_v[0] = pb_pin_val;
  assign pin_we_v[1]  = pa_pin_we;
  assign pin_val_v[1] = pa_pin_val;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign port_wr[g] = bus_we && ((ofs == 4'(g)) || (g == 1 && ofs == OFS_PA_NQ));
    assign dir_wr[g]  = bus_we && (ofs == 4'(g + NPORT));
    pir_port u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .data_we(port_wr[g]),
      .dir_we (dir_wr[g]),
      .wdata  (bus_wdata),
      .pin_we (pin_we_v[g]),
      .pin_val(pin_val_v[g]),
      .data_q (port_q[g]),
      .dir_q  (dir_q[g])
    );
  end

  // Handshake acknowledge: only the plain port offsets clear flags.
  assign hs_clr = ((bus_we && ofs == OFS_PB) ? HS_MASK_B : '0)
                | ((bus_we && ofs == OFS_PA) ? HS_MASK_A : '0);
  assign wr_flag = bus_we && (ofs == OFS_FLAG);
  assign wr_en   = bus_we && (ofs == OFS_EN);

  pir_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(flag_set),
    .clr_req(flag_clr),
    .hs_clr (hs_clr),
    .flag_we(wr_flag),
    .en_we  (wr_en),
    .wdata  (bus_wdata),
    .flag_q (flag_q),
    .en_q   (ier_q),
    .irq    (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q <= '0;
      pcr_q <= '0;
    end else if (bus_we) begin
      if (ofs == OFS_AUX) aux_q <= bus_wdata;
      if (ofs == OFS_PCR) pcr_q <= bus_wdata;
    end
  end

  assign ca2_out = pcr_q[CA2_BIT];

  always_comb begin
    bus_rdata = '0;
    case (ofs)
      4'h0:          bus_rdata = port_view(port_q[0], dir_q[0]);
      4'h1, 4'hF:    bus_rdata = port_view(port_q[1], dir_q[1]);
      4'h2:          bus_rdata = dir_q[0];
      4'h3:          bus_rdata = dir_q[1];
      OFS_AUX:       bus_rdata = aux_q;
      OFS_PCR:       bus_rdata = pcr_q;
      OFS_FLAG:      bus_rdata = status_byte(flag_q, ier_q);
      OFS_EN:        bus_rdata = {1'b1, ier_q};
      default:       bus_rdata = '0;
    endcase
  end

  assign pa_dir = dir_q[1];
  assign pb_dir = dir_q[0];
  assign pa_out = port_q[1] & dir_q[1];
  assign pb_out = port_q[0] & dir_q[0];
endmodule

// File: rtl/pir_checker.sv
module pir_checker
  import pir_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] pa_pin_we,
  input logic [NF-1:0] flag_set,
  input logic [NF-1:0] flag_clr,
  input logic [DW-1:0] pa_out,
  input logic [DW-1:0] pa_dir,
  input logic          ca2_out,
  input logic          irq,
  input logic [NF-1:0] flag_q,
  input logic [NF-1:0] ier_q
);
  logic [3:0] a;
  assign a = bus_addr[3:0];

  assert_port_write_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (a == 4'h1) && (pa_pin_we == '0)) |=> (pa_out == $past(bus_wdata & pa_dir)));

  assert_hs_clear_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (a == 4'h0) && (flag_set[4:3] == 2'b00)) |=> (flag_q[4:3] == 2'b00));

  assert_quiet_write_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (a == 4'hF) && (flag_clr[1:0] == 2'b00))
      |=> ((flag_q[1:0] & $past(flag_q[1:0])) == $past(flag_q[1:0])));

  assert_enable_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (a == 4'hE) && bus_wdata[7])
      |=> ((ier_q & $past(bus_wdata[6:0])) == $past(bus_wdata[6:0])));

  assert_irq_on_enabled_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(flag_set & ier_q)) && !(bus_we && (a == 4'hE))) |=> irq);

  assert_flag_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (a == 4'hD) && ((bus_wdata[6:0] & flag_set) == '0))
      |=> ((flag_q & $past(bus_wdata[6:0])) == '0));

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == '0) |-> !irq);

  assert_ca2_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (a == 4'hC)) |=> (ca2_out == $past(bus_wdata[1])));
endmodule

bind port_irq_regs pir_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .pa_pin_we(pa_pin_we),
  .flag_set (flag_set),
  .flag_clr (flag_clr),
  .pa_out   (pa_out),
  .pa_dir   (pa_dir),
  .ca2_out  (ca2_out),
  .irq      (irq),
  .flag_q   (flag_q),
  .ier_q    (ier_q)
);

// File: tb/port_irq_regs_tb.sv
`timescale 1ns/1ps
module port_irq_regs_tb;
  localparam int AW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pa_pin_we = '0, pa_pin_val = '0, pb_pin_we = '0, pb_pin_val = '0;
  logic [6:0] flag_set = '0, flag_clr = '0;
  logic [7:0] pa_out, pa_dir, pb_out, pb_dir;
  logic       ca2_out, irq;

  always #4 clk = ~clk;  // 125 MHz

  port_irq_regs #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_pin_we(pa_pin_we), .pa_pin_val(pa_pin_val),
    .pb_pin_we(pb_pin_we), .pb_pin_val(pb_pin_val),
    .flag_set(flag_set), .flag_clr(flag_clr),
    .pa_out(pa_out), .pa_dir(pa_dir), .pb_out(pb_out), .pb_dir(pb_dir),
    .ca2_out(ca2_out), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Behavioural model state
  int m_pa, m_pb, m_da, m_db, m_aux, m_pcr, m_flg, m_en;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int view(input int d, input int dir);
    return ((d & dir) | (~dir & 255)) & 255;
  endfunction

  function automatic int model_read(input int addr);
    int o = addr % 16;
    if (o == 0) return view(m_pb, m_db);
    if (o == 1 || o == 15) return view(m_pa, m_da);
    if (o == 2) return m_db;
    if (o == 3) return m_da;
    if (o == 11) return m_aux;
    if (o == 12) return m_pcr;
    if (o == 13) return m_flg + (((m_flg & m_en) != 0) ? 128 : 0);
    if (o == 14) return 128 + m_en;
    return 0;
  endfunction

  function automatic string read_tag(input int addr);
    int o = addr % 16;
    if (o <= 3 || o == 15) return "R3";
    if (o == 13) return "R10";
    if (o == 14) return "R7";
    if (o == 11 || o == 12) return "R11";
    return "R1";
  endfunction

  task automatic model_clock();
    int o = int'(bus_addr) % 16;
    int wd = int'(bus_wdata);
    int clr = int'(flag_clr);
    if (bus_we) begin
      case (o)
        0: begin m_pb = wd & m_db; clr = clr | 'h18; end
        1: begin m_pa = wd & m_da; clr = clr | 'h03; end
        15: m_pa = wd & m_da;
        2: m_db = wd;
        3: m_da = wd;
        11: m_aux = wd;
        12: m_pcr = wd;
        13: clr = clr | (wd & 127);
        14: m_en = (wd >= 128) ? (m_en | (wd & 127)) : (m_en & ~(wd & 127) & 127);
        default: ;
      endcase
    end
    m_pa = (m_pa & ~int'(pa_pin_we) & 255) | (int'(pa_pin_val) & int'(pa_pin_we));
    m_pb = (m_pb & ~int'(pb_pin_we) & 255) | (int'(pb_pin_val) & int'(pb_pin_we));
    m_flg = ((m_flg & ~clr) | int'(flag_set)) & 127;
  endtask

  task automatic compare_all();
    int e = model_read(int'(bus_addr));
    check(bus_rdata == e[7:0], read_tag(int'(bus_addr)), bus_rdata, e);
    check(irq == ((m_flg & m_en) != 0), "R10", irq, int'((m_flg & m_en) != 0));
    check(pa_out == 8'(m_pa & m_da), "R2", pa_out, m_pa & m_da);
    check(pb_out == 8'(m_pb & m_db), "R2", pb_out, m_pb & m_db);
    check(pa_dir == 8'(m_da) && pb_dir == 8'(m_db), "R3", {pa_dir, pb_dir}, (m_da << 8) | m_db);
    check(ca2_out == m_pcr[1], "R11", ca2_out, m_pcr[1]);
  endtask

  // One bus cycle: drive at falling edge, compare shortly after, update model at the rising edge.
  task automatic cyc(input bit we, input int addr, input int wd,
                     input int paw = 0, input int pav = 0, input int pbw = 0, input int pbv = 0,
                     input int fs = 0, input int fc = 0);
    @(negedge clk);
    bus_we = we; bus_addr = 8'(addr); bus_wdata = 8'(wd);
    pa_pin_we = 8'(paw); pa_pin_val = 8'(pav); pb_pin_we = 8'(pbw); pb_pin_val = 8'(pbv);
    flag_set = 7'(fs); flag_clr = 7'(fc);
    #1 compare_all();
    @(posedge clk);
    model_clock();
  endtask

  task automatic rd(input int addr, input int exp, input string tag);
    @(negedge clk);
    bus_we = 0; bus_addr = 8'(addr); bus_wdata = 0;
    pa_pin_we = 0; pb_pin_we = 0; flag_set = 0; flag_clr = 0;
    #1;
    check(bus_rdata == 8'(exp), tag, bus_rdata, exp);
    compare_all();
    @(posedge clk);
    model_clock();
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_pa = 0; m_pb = 0; m_da = 0; m_db = 0; m_aux = 0; m_pcr = 0; m_flg = 0; m_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R12 reset state
    rd(0, 'hFF, "R12");
    rd(14, 'h80, "R12");
    rd(13, 'h00, "R12");
    check(irq == 1'b0, "R12", irq, 0);

    // R2 / R3 masked port write
    cyc(1, 2, 'h0F);
    cyc(1, 0, 'hA5);
    rd(0, 'hF5, "R3");
    check(pb_out == 8'h05, "R2", pb_out, 'h05);

    // R1 upper address bits ignored, unused offset reads zero
    cyc(1, 'h23, 'hF0);
    rd('h13, 'hF0, "R1");
    cyc(1, 5, 'hFF);
    rd('h95, 'h00, "R1");

    // R4 pin update overrides same-cycle bus write
    cyc(1, 1, 'hFF, 'hFF, 'h3C);
    rd(1, 'h3F, "R4");
    check(pa_out == 8'h30, "R4", pa_out, 'h30);

    // R8 flag set strobes, no enables yet
    cyc(0, 0, 0, 0, 0, 0, 0, 'h7F);
    rd(13, 'h7F, "R8");
    check(irq == 1'b0, "R8", irq, 0);

    // R5 port B write clears CB flags
    cyc(1, 0, 0);
    rd(13, 'h67, "R5");
    // R6 quiet alias keeps CA flags
    cyc(1, 15, 'h00);
    rd(13, 'h67, "R6");
    cyc(1, 1, 'h00);
    rd(13, 'h64, "R5");

    // R7 enable set/clear, R10 summary bit and irq
    cyc(1, 14, 'h82);
    rd(14, 'h82, "R7");
    check(irq == 1'b0, "R10", irq, 0);
    cyc(1, 14, 'hA0);
    rd(13, 'hE4, "R10");
    check(irq == 1'b1, "R10", irq, 1);
    cyc(1, 14, 'h20);
    rd(14, 'h82, "R7");
    check(irq == 1'b0, "R10", irq, 0);

    // R9 flag write clears ones only
    cyc(1, 13, 'h44);
    rd(13, 'h20, "R9");

    // R8 set wins over clear
    cyc(0, 0, 0, 0, 0, 0, 0, 'h02, 'h02);
    rd(13, 'hA2, "R8");
    check(irq == 1'b1, "R8", irq, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 'h02);
    rd(13, 'h20, "R8");

    // R11 control bytes and CA2
    cyc(1, 12, 'h02);
    rd(12, 'h02, "R11");
    check(ca2_out == 1'b1, "R11", ca2_out, 1);
    cyc(1, 11, 'h5A);
    rd(11, 'h5A, "R11");

    // Mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      cyc(r < 60, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
          (r % 7 == 0) ? int'($urandom_range(0, 255)) : 0, int'($urandom_range(0, 255)),
          (r % 5 == 0) ? int'($urandom_range(0, 255)) : 0, int'($urandom_range(0, 255)),
          (r % 4 == 0) ? int'($urandom_range(0, 127)) : 0,
          (r % 6 == 0) ? int'($urandom_range(0, 127)) : 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule